// File: doc/BRIEF.md
# Conversion Queue Freeze Controller

This block decides when a queued conversion sequencer stops for a debug halt. A freeze request is the debug halt line qualified by an enable bit. When no conversion is running the block freezes on the next clock. When a conversion is running it waits for that conversion to finish, unless software rewrites the queue mode or aborts the queue first. In that case it freezes at once.

While frozen, the block does the following:
- It holds the conversion clock prescaler and the interval timer in reset.
- It drops external trigger pulses instead of latching them.
- It records the command entry the queue would execute next.

Mode writes and aborts from the register side keep working while frozen. The sequencer resumes from the recorded entry, or from a newly written entry, once the request goes away.

A small built-in sequencer stands in for the real conversion queue so that the freeze logic can be exercised on its own. It has a command pointer, a fixed-length conversion counter and a free-running interval timer.

Top module: `queue_freeze_top`

## Requirements
- R1: With `freezeEn` low, `freezeLine` has no effect: `frozen` stays 0 and conversions keep advancing.
- R2: A qualified request (`freezeLine` and `freezeEn` both high) while `convBusy` is 0 sets `frozen` at the next clock edge.
- R3: A qualified request while a conversion runs, with no mode write or abort, leaves `frozen` at 0 until the cycle in which `convDone` is high. `frozen` goes to 1 at the edge that ends that cycle.
- R4: A mode write (`modeWr`) or an abort (`q2Abort`) during a running conversion with a qualified request sets `frozen` at the next edge. The conversion is dropped without a `convDone`.
- R5: When freeze is entered with the queue active, `savedPtr` takes the entry the queue will execute next:
  - `qPtr`+1 after a completed conversion, or 0 after the last entry;
  - `modeEntry` after a mode write;
  - `qPtr` unchanged after an abort.
  Entering freeze with the queue idle leaves `savedPtr` unchanged.
- R6: While `frozen` is 1, the following hold:
  - `prescHold`, `timerHold` and `trigBlock` are 1;
  - `ivlTimer` reads 0;
  - `convDone` stays 0.
  Outside freeze, `ivlTimer` increments by one per clock.
- R7: An `extTrig` pulse during freeze is discarded: after release the queue is still inactive.
- R8: A mode write during freeze is accepted. `qPtr` loads `modeEntry`, and the first conversion after release runs on that entry.
- R9: `frozen` clears at the first edge where the request is low. The queue resumes from `qPtr` with a full-length conversion.
- R10: A request first presented in the same cycle as `convDone` is treated as a completed conversion: `savedPtr` points past the finished entry.
- R11: Queue operation works as follows:
  - `extTrig` while idle and not freezing starts the queue at `qPtr`;
  - each conversion lasts `CONV_CYCLES` clocks, with `convDone` high in the last one;
  - after a completion `qPtr` advances by one;
  - the completion of entry `QLEN-1` stops the queue and sets `qPtr` to 0.
- R12: `q2Abort` takes priority over `modeWr` in the same cycle: the queue stops and `qPtr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| freezeLine | input | 1 | Debug freeze request line |
| freezeEn | input | 1 | Enables response to the freeze line |
| extTrig | input | 1 | External trigger; starts an idle queue |
| modeWr | input | 1 | Queue mode write strobe; (re)starts the queue at `modeEntry` |
| modeEntry | input | PTR_W | Entry selected by a mode write |
| q2Abort | input | 1 | Queue abort strobe |
| frozen | output | 1 | Block is in freeze |
| queueActive | output | 1 | Queue is executing |
| convBusy | output | 1 | A conversion is running |
| convDone | output | 1 | Last cycle of a conversion |
| qPtr | output | PTR_W | Current command entry |
| savedPtr | output | PTR_W | Entry recorded at freeze entry |
| prescHold | output | 1 | Conversion clock prescaler held in reset |
| timerHold | output | 1 | Interval timer held in reset |
| trigBlock | output | 1 | External trigger capture blocked |
| ivlTimer | output | TMR_W | Interval timer value |

## Verification
The embedded assertions check the rules that hold on every cycle:
- freeze never rises without a qualified request;
- it falls one clock after the request drops;
- it is immediate when idle and never early during a plain conversion;
- the interval timer reads zero while frozen;
- the recorded pointer matches the pointer the sequencer moves to;
- the queue stops after its last entry.

Only the bench's scenarios can show the following, because each depends on a specific history:
- a trigger dropped during freeze stays lost after release;
- a mode write made while frozen chooses the resume entry;
- abort wins over a simultaneous mode write;
- a request landing exactly on a completion counts as completed.

// File: rtl/qfz_pkg.sv
`timescale 1ns/1ps
package qfz_pkg;
  // Strobes from freeze control to the sequencer datapath
  typedef struct packed {
    logic hold;     // freeze state after the coming edge
    logic savePtr;  // record the next entry at this edge
  } qfz_ctl_t;
endpackage

// File: rtl/qfz_ctrl.sv
`timescale 1ns/1ps
module qfz_ctrl
  import qfz_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     freezeLine,
  input  logic     freezeEn,
  input  logic     modeWr,
  input  logic     q2Abort,
  input  logic     qActive,
  input  logic     convBusy,
  input  logic     convDone,
  output logic     frozen,
  output qfz_ctl_t ctl
);
  logic freezeReq;
  logic frozenNext;

  assign freezeReq = freezeLine & freezeEn;

  // Enter when idle, at completion, or on a mid-conversion mode write / abort
  assign frozenNext = freezeReq &
                      (frozen | ~convBusy | convDone | modeWr | q2Abort);

  always_comb begin
    ctl.hold    = frozenNext;
    ctl.savePtr = frozenNext & ~frozen & qActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frozen <= 1'b0;
    else       frozen <= frozenNext;
  end

  // R1
  freeze_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frozen) |-> $past(freezeLine && freezeEn));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !(freezeLine && freezeEn)) |=> !frozen);

  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && freezeLine && freezeEn && !convBusy) |=> frozen);

  // R3
  defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && freezeLine && freezeEn && convBusy && !convDone
     && !modeWr && !q2Abort) |=> !frozen);
endmodule

// File: rtl/qfz_seq.sv
`timescale 1ns/1ps
module qfz_seq
  import qfz_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int QLEN        = 12,
  parameter int CONV_CYCLES = 4,
  parameter int TMR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frozen,
  input  qfz_ctl_t         ctl,
  input  logic             extTrig,
  input  logic             modeWr,
  input  logic [PTR_W-1:0] modeEntry,
  input  logic             q2Abort,
  output logic             qActive,
  output logic             convBusy,
  output logic             convDone,
  output logic [PTR_W-1:0] qPtr,
  output logic [PTR_W-1:0] savedPtr,
  output logic [TMR_W-1:0] ivlCnt
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(QLEN - 1);

  logic [CNT_W-1:0] convCnt;
  logic [PTR_W-1:0] ptrNext;
  logic             actNext;
  logic             cntClear;

  assign convBusy = qActive & ~frozen;
  assign convDone = convBusy & (convCnt == CNT_LAST);
  assign cntClear = ~convBusy | convDone | modeWr | q2Abort | ctl.hold;

  always_comb begin
    ptrNext = qPtr;
    actNext = qActive;
    if (q2Abort) begin
      actNext = 1'b0;
    end else if (modeWr) begin
      actNext = 1'b1;
      ptrNext = modeEntry;
    end else if (convDone) begin
      if (qPtr == PTR_LAST) begin
        actNext = 1'b0;
        ptrNext = '0;
      end else begin
        ptrNext = qPtr + 1'b1;
      end
    end else if (extTrig && !qActive && !ctl.hold) begin
      actNext = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qActive  <= 1'b0;
      qPtr     <= '0;
      savedPtr <= '0;
      convCnt  <= '0;
      ivlCnt   <= '0;
    end else begin
      qActive <= actNext;
      qPtr    <= ptrNext;
      if (ctl.savePtr) savedPtr <= ptrNext;
      convCnt <= cntClear ? '0 : convCnt + 1'b1;
      ivlCnt  <= ctl.hold ? '0 : ivlCnt + 1'b1;
    end
  end

  // R6
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> (ivlCnt == '0));

  // R5
  save_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.savePtr) |-> (savedPtr == qPtr));

  // R11
  queue_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && qPtr == PTR_LAST && !modeWr && !q2Abort)
      |=> (!qActive && qPtr == '0));
endmodule

// File: rtl/queue_freeze_top.sv
`timescale 1ns/1ps
module queue_freeze_top
  import qfz_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int QLEN        = 12,
  parameter int CONV_CYCLES = 4,
  parameter int TMR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             freezeLine,
  input  logic             freezeEn,
  input  logic             extTrig,
  input  logic             modeWr,
  input  logic [PTR_W-1:0] modeEntry,
  input  logic             q2Abort,
  output logic             frozen,
  output logic             queueActive,
  output logic             convBusy,
  output logic             convDone,
  output logic [PTR_W-1:0] qPtr,
  output logic [PTR_W-1:0] savedPtr,
  output logic             prescHold,
  output logic             timerHold,
  output logic             trigBlock,
  output logic [TMR_W-1:0] ivlTimer
);
  qfz_ctl_t ctl;

  qfz_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .freezeLine(freezeLine), .freezeEn(freezeEn),
    .modeWr(modeWr), .q2Abort(q2Abort),
    .qActive(queueActive), .convBusy(convBusy), .convDone(convDone),
    .frozen(frozen), .ctl(ctl)
  );

  qfz_seq #(
    .PTR_W(PTR_W), .QLEN(QLEN), .CONV_CYCLES(CONV_CYCLES), .TMR_W(TMR_W)
  ) u_seq (
    .clk(clk), .rstN(rstN), .frozen(frozen), .ctl(ctl),
    .extTrig(extTrig), .modeWr(modeWr), .modeEntry(modeEntry),
    .q2Abort(q2Abort),
    .qActive(queueActive), .convBusy(convBusy), .convDone(convDone),
    .qPtr(qPtr), .savedPtr(savedPtr), .ivlCnt(ivlTimer)
  );

  assign prescHold = frozen;
  assign timerHold = frozen;
  assign trigBlock = frozen;
endmodule

// File: tb/queue_freeze_top_tb.sv
`timescale 1ns/1ps
module queue_freeze_top_tb;
  localparam int PTR_W = 4;
  localparam int TMR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freezeLine = 1'b0, freezeEn = 1'b0, extTrig = 1'b0;
  logic modeWr = 1'b0, q2Abort = 1'b0;
  logic [PTR_W-1:0] modeEntry = '0;
  logic frozen, queueActive, convBusy, convDone;
  logic prescHold, timerHold, trigBlock;
  logic [PTR_W-1:0] qPtr, savedPtr;
  logic [TMR_W-1:0] ivlTimer;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  queue_freeze_top #(.PTR_W(PTR_W), .QLEN(4), .CONV_CYCLES(3), .TMR_W(TMR_W)) u_dut (
    .clk(clk), .rstN(rstN), .freezeLine(freezeLine), .freezeEn(freezeEn),
    .extTrig(extTrig), .modeWr(modeWr), .modeEntry(modeEntry), .q2Abort(q2Abort),
    .frozen(frozen), .queueActive(queueActive), .convBusy(convBusy),
    .convDone(convDone), .qPtr(qPtr), .savedPtr(savedPtr),
    .prescHold(prescHold), .timerHold(timerHold), .trigBlock(trigBlock),
    .ivlTimer(ivlTimer)
  );

  // {freezeLine, freezeEn, extTrig, expFrozen, expActive, expDone, expPtr[3:0]}
  // Covers R11 queue run and wrap, R1 disabled request, R3 deferred entry.
  localparam logic [9:0] VEC [15] = '{
    10'b001_010_0000, 10'b000_010_0000, 10'b000_011_0000,
    10'b100_010_0001, 10'b100_010_0001, 10'b110_011_0001,
    10'b110_110_0010, 10'b110_110_0010, 10'b000_010_0010,
    10'b000_010_0010, 10'b000_011_0010, 10'b000_010_0011,
    10'b000_010_0011, 10'b000_011_0011, 10'b000_000_0000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    logic [TMR_W-1:0] tmrSnap;
    #12;
    check("R6 reset frozen", frozen, 0);
    check("R11 reset active", queueActive, 0);
    check("R11 reset ptr", qPtr, 0);
    @(negedge clk);
    rstN = 1'b1;
    step();

    for (int i = 0; i < 15; i++) begin
      freezeLine = VEC[i][9];
      freezeEn   = VEC[i][8];
      extTrig    = VEC[i][7];
      step();
      check($sformatf("R11 R1 R3 row%0d frozen", i), frozen, VEC[i][6]);
      check($sformatf("R11 row%0d active", i), queueActive, VEC[i][5]);
      check($sformatf("R11 row%0d done", i), convDone, VEC[i][4]);
      check($sformatf("R11 row%0d ptr", i), qPtr, VEC[i][3:0]);
    end
    check("R5 saved after completion", savedPtr, 2);

    // R2 idle entry, R6 holds, R7 trigger dropped, R9 release
    freezeLine = 1; freezeEn = 1; extTrig = 0;
    step();
    check("R2 idle freeze", frozen, 1);
    check("R5 idle keeps saved", savedPtr, 2);
    check("R6 prescHold", prescHold, 1);
    check("R6 timerHold", timerHold, 1);
    check("R6 trigBlock", trigBlock, 1);
    check("R6 timer zero", ivlTimer, 0);
    extTrig = 1;
    step();
    check("R6 no done in freeze", convDone, 0);
    extTrig = 0; freezeLine = 0;
    step();
    check("R9 release", frozen, 0);
    check("R6 timer restarts", ivlTimer, 1);
    step();
    check("R7 trigger discarded", queueActive, 0);
    tmrSnap = ivlTimer;
    step();
    check("R6 timer counts", ivlTimer, tmrSnap + 1'b1);

    // R10 request on the completion cycle
    extTrig = 1; step(); extTrig = 0;
    step(); step();
    check("R11 done visible", convDone, 1);
    freezeLine = 1; freezeEn = 1;
    step();
    check("R10 frozen", frozen, 1);
    check("R10 saved past entry", savedPtr, 1);
    freezeLine = 0;
    step();
    check("R9 released", frozen, 0);
    step(); step();
    check("R9 resume done", convDone, 1);
    check("R9 resume ptr", qPtr, 1);
    step();
    check("R11 advance", qPtr, 2);

    // R4 mode write mid-conversion
    step();
    freezeLine = 1; modeWr = 1; modeEntry = 3;
    step();
    modeWr = 0;
    check("R4 immediate freeze", frozen, 1);
    check("R5 saved mode entry", savedPtr, 3);
    check("R4 ptr loaded", qPtr, 3);

    // R8 mode write during freeze
    modeWr = 1; modeEntry = 1;
    step();
    modeWr = 0;
    check("R8 ptr written", qPtr, 1);
    check("R8 still frozen", frozen, 1);
    check("R5 saved unchanged", savedPtr, 3);
    freezeLine = 0;
    step(); step(); step();
    check("R8 resume done", convDone, 1);
    check("R8 resume ptr", qPtr, 1);
    step(); step();

    // R4 / R12 abort with simultaneous mode write
    freezeLine = 1; q2Abort = 1; modeWr = 1; modeEntry = 0;
    step();
    q2Abort = 0; modeWr = 0;
    check("R4 abort freeze", frozen, 1);
    check("R12 abort stops queue", queueActive, 0);
    check("R12 ptr kept", qPtr, 2);
    check("R5 saved on abort", savedPtr, 2);
    freezeLine = 0;
    step();
    check("R12 stays idle", queueActive, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule